// File: doc/BRIEF.md
# Interrupt Source Sense and Pending Unit

This block sits in front of an interrupt prioritiser. It watches 32 request inputs that are already synchronous to its clock. Source 0 is the fast request, source 1 is the system request, and sources 2 to 31 are peripheral requests, one per peripheral number. Each source has its own two-bit sense setting, which picks level or edge detection and the active polarity.

For every source the block keeps a pending bit and an enable (mask) bit. Software drives four write-one command vectors: enable, disable, force-pending and clear-pending. A one in any bit acts on that source, and a zero has no effect. Forcing a source pending lets software raise an interrupt on its own. When the prioritiser reads a vector, it pulses an acknowledge with the serviced source number. If that source is edge-sensed, its latched request is dropped.

The outputs are the pending vector, the enable vector, their bitwise AND (the requests that may go on to arbitration) and a direct copy of the request inputs.

Top module: `irq_sense_top`

## Requirements
- R1: While reset is active, and on the first cycle after it, the pending, enable and masked-active vectors are all zero.
- R2: The sense setting of source i is `srcMode[2*i+1:2*i]`. The code 00 means level, active high. The code 01 means level, active low. The code 10 means rising edge. The code 11 means falling edge.
- R3: A one in `enableCmd` sets the enable bit and a one in `disableCmd` clears it, both from the next clock edge. If both are one for the same bit in the same cycle, the bit ends up enabled. Zero bits leave the enable bit unchanged.
- R4: For a level-sensed source, the pending bit shows the active level sampled at the previous clock edge. A clear command sent while the level is active has no effect.
- R5: A one in `forceSetCmd` makes the source pending from the next edge, for any sense mode. The bit stays pending until a one in `forceClrCmd` arrives, or until an acknowledge arrives for an edge-sensed source. If a force and a clear hit the same bit in the same cycle, the force wins.
- R6: An edge-sensed source becomes pending at the clock edge where its input first shows the selected transition compared with the previous cycle's sample. It stays pending after the input returns to idle.
- R7: When `ackValid` is high, the source numbered `ackId` is acknowledged. If that source is edge-sensed, its pending bit clears at the next edge. If it is level-sensed, its pending bit is unaffected. An edge or a force that arrives in the same cycle as the acknowledge wins over it.
- R8: `activeVec` equals `pendingVec & maskVec` at all times.
- R9: `rawVec` equals `irqIn` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Synchronous request inputs, one per source |
| srcMode | input | 64 | Two sense bits per source |
| enableCmd | input | 32 | Write-one enable strobes |
| disableCmd | input | 32 | Write-one disable strobes |
| forceSetCmd | input | 32 | Write-one force-pending strobes |
| forceClrCmd | input | 32 | Write-one clear-pending strobes |
| ackValid | input | 1 | Acknowledge pulse from the vector read |
| ackId | input | 5 | Number of the acknowledged source |
| pendingVec | output | 32 | Pending bit per source |
| maskVec | output | 32 | Enable bit per source |
| activeVec | output | 32 | Pending and enabled |
| rawVec | output | 32 | Current request inputs |

## Verification
The pending, enable and masked-active results are registered once. A stimulus applied before a clock edge therefore appears just after that same edge, and no later. The driver applies each stimulus on the falling edge and queues the result expected for it. The monitor takes one queued item a quarter period after the next rising edge, so each comparison lands in the cycle where the result is due. The raw input copy has no delay, so it is compared one time step after the inputs are driven.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int unsigned IrqCount = 32;
  localparam int unsigned IrqIdW   = $clog2(IrqCount);
  localparam int unsigned ModeW    = 2;

  typedef logic [IrqCount-1:0] irqVec_t;

  // sense code per source; bit 1 selects edge, bit 0 selects the low/falling polarity
  typedef enum logic [ModeW-1:0] {
    SenseHigh = 2'b00,
    SenseLow  = 2'b01,
    SenseRise = 2'b10,
    SenseFall = 2'b11
  } senseMode_t;

  // strobes from control to datapath
  typedef struct packed {
    irqVec_t maskOn;
    irqVec_t maskOff;
    irqVec_t forceSet;
    irqVec_t forceClr;
    irqVec_t ackHit;
    irqVec_t edgeSel;
    irqVec_t lowSel;
  } senseStrobe_t;
endpackage

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [IrqCount*ModeW-1:0] srcMode,
  input  irqVec_t                   enableCmd,
  input  irqVec_t                   disableCmd,
  input  irqVec_t                   forceSetCmd,
  input  irqVec_t                   forceClrCmd,
  input  logic                      ackValid,
  input  logic [IrqIdW-1:0]         ackId,
  output senseStrobe_t              strb
);
  irqVec_t edgeVec;
  irqVec_t lowVec;
  irqVec_t ackVec;

  for (genvar i = 0; i < IrqCount; i++) begin : g_src
    senseMode_t modeI;
    assign modeI      = senseMode_t'(srcMode[ModeW*i +: ModeW]);
    assign edgeVec[i] = (modeI == SenseRise) || (modeI == SenseFall);
    assign lowVec[i]  = (modeI == SenseLow)  || (modeI == SenseFall);
    // acknowledge only reaches edge-latched requests
    assign ackVec[i]  = ackValid && (ackId == IrqIdW'(i)) && edgeVec[i];
  end

  always_comb begin
    strb          = '0;
    strb.maskOn   = enableCmd;
    strb.maskOff  = disableCmd;
    strb.forceSet = forceSetCmd;
    strb.forceClr = forceClrCmd;
    strb.ackHit   = ackVec;
    strb.edgeSel  = edgeVec;
    strb.lowSel   = lowVec;
  end

  // R7: an acknowledge selects at most one source
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.ackHit));

  // R7: no acknowledge strobe without a request on the port
  a_r7_ack_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |-> (strb.ackHit == '0));
endmodule

// File: rtl/irq_sense_dp.sv
module irq_sense_dp
  import irq_sense_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  irqVec_t      irqIn,
  input  senseStrobe_t strb,
  output irqVec_t      pendingVec,
  output irqVec_t      maskVec,
  output irqVec_t      activeVec
);
  irqVec_t prevIn;
  irqVec_t latchQ;
  irqVec_t pendQ;
  irqVec_t maskQ;

  irqVec_t qualNow;
  irqVec_t qualPrev;
  irqVec_t edgeHit;
  irqVec_t latchNext;
  irqVec_t pendNext;
  irqVec_t maskNext;

  always_comb begin
    qualNow   = irqIn  ^ strb.lowSel;
    qualPrev  = prevIn ^ strb.lowSel;
    edgeHit   = strb.edgeSel & qualNow & ~qualPrev;
    // set sources win over clear sources
    latchNext = strb.forceSet | edgeHit | (latchQ & ~(strb.forceClr | strb.ackHit));
    pendNext  = latchNext | (~strb.edgeSel & qualNow);
    maskNext  = strb.maskOn | (maskQ & ~strb.maskOff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn <= '0;
      latchQ <= '0;
      pendQ  <= '0;
      maskQ  <= '0;
    end else begin
      prevIn <= irqIn;
      latchQ <= latchNext;
      pendQ  <= pendNext;
      maskQ  <= maskNext;
    end
  end

  assign pendingVec = pendQ;
  assign maskVec    = maskQ;
  assign activeVec  = pendQ & maskQ;

  // R3: every enable strobe leaves its bit set
  a_r3_enable_sets: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskOn != '0) |=> ((maskQ & $past(strb.maskOn)) == $past(strb.maskOn)));

  // R3: a disable without a matching enable leaves the bit clear
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskOff != '0) |=> ((maskQ & $past(strb.maskOff & ~strb.maskOn)) == '0));

  // R5: a forced source is pending on the next cycle
  a_r5_force_pends: assert property (@(posedge clk) disable iff (!rstN)
    (strb.forceSet != '0) |=> ((pendQ & $past(strb.forceSet)) == $past(strb.forceSet)));

  // R6: a latched request only drops after a clear or an acknowledge
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(latchQ) & ~latchQ & ~$past(strb.forceClr | strb.ackHit)) == '0));

  // R4: an active level is reflected as pending one cycle later
  a_r4_level_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(~strb.edgeSel & (irqIn ^ strb.lowSel)) & ~pendQ) == '0));

  // R7: acknowledge strobes never target level-sensed sources
  a_r7_ack_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackHit & ~strb.edgeSel) == '0);
endmodule

// File: rtl/irq_sense_top.sv
module irq_sense_top
  import irq_sense_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [IrqCount-1:0]       irqIn,
  input  logic [IrqCount*ModeW-1:0] srcMode,
  input  logic [IrqCount-1:0]       enableCmd,
  input  logic [IrqCount-1:0]       disableCmd,
  input  logic [IrqCount-1:0]       forceSetCmd,
  input  logic [IrqCount-1:0]       forceClrCmd,
  input  logic                      ackValid,
  input  logic [IrqIdW-1:0]         ackId,
  output logic [IrqCount-1:0]       pendingVec,
  output logic [IrqCount-1:0]       maskVec,
  output logic [IrqCount-1:0]       activeVec,
  output logic [IrqCount-1:0]       rawVec
);
  senseStrobe_t strb;

  irq_sense_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .srcMode     (srcMode),
    .enableCmd   (enableCmd),
    .disableCmd  (disableCmd),
    .forceSetCmd (forceSetCmd),
    .forceClrCmd (forceClrCmd),
    .ackValid    (ackValid),
    .ackId       (ackId),
    .strb        (strb)
  );

  irq_sense_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .irqIn      (irqIn),
    .strb       (strb),
    .pendingVec (pendingVec),
    .maskVec    (maskVec),
    .activeVec  (activeVec)
  );

  assign rawVec = irqIn;

  // R8: the masked-active output never shows a disabled or idle source
  a_r8_active_subset: assert property (@(posedge clk) disable iff (!rstN)
    ((activeVec & ~pendingVec) | (activeVec & ~maskVec)) == '0);
endmodule

// File: tb/irq_sense_top_tb_top.sv
module irq_sense_top_tb_top;
  localparam int ClkPeriod = 10;
  localparam logic [31:0] IdleIrq = 32'h0000_000A;

  typedef struct {
    logic [31:0] pend;
    logic [31:0] mask;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = IdleIrq;
  logic [63:0] srcMode;
  logic [31:0] enableCmd = '0, disableCmd = '0, forceSetCmd = '0, forceClrCmd = '0;
  logic        ackValid = 1'b0;
  logic [4:0]  ackId = '0;
  logic [31:0] pendingVec, maskVec, activeVec, rawVec;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  always #(ClkPeriod/2) clk = ~clk;

  irq_sense_top dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .srcMode(srcMode),
    .enableCmd(enableCmd), .disableCmd(disableCmd),
    .forceSetCmd(forceSetCmd), .forceClrCmd(forceClrCmd),
    .ackValid(ackValid), .ackId(ackId),
    .pendingVec(pendingVec), .maskVec(maskVec),
    .activeVec(activeVec), .rawVec(rawVec)
  );

  // modes: 0 high level, 1 low level, 2 rise, 3 fall, 4 rise, 5 and up high level
  initial begin
    srcMode = '0;
    srcMode[3:2] = 2'b01;
    srcMode[5:4] = 2'b10;
    srcMode[7:6] = 2'b11;
    srcMode[9:8] = 2'b10;
  end

  task automatic checkVec(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // driver: apply one stimulus at the falling edge, queue the result due after the next rising edge
  task automatic tick(input string tag, input logic [31:0] expPend, input logic [31:0] expMask);
    expItem_t item;
    #1;
    checkVec({tag, " R9 raw"}, rawVec, irqIn);
    item.pend = expPend;
    item.mask = expMask;
    item.tag  = tag;
    expQ.push_back(item);
    @(negedge clk);
    enableCmd = '0; disableCmd = '0; forceSetCmd = '0; forceClrCmd = '0; ackValid = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(ClkPeriod/4);
      if (expQ.size() > 0) begin
        expItem_t item;
        item = expQ.pop_front();
        checkVec({item.tag, " pending"}, pendingVec, item.pend);
        checkVec({item.tag, " mask"}, maskVec, item.mask);
        checkVec({item.tag, " R8 active"}, activeVec, item.pend & item.mask);
      end
    end
  end

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(ClkPeriod * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] m;
    repeat (3) @(negedge clk);
    checkVec("R1 reset pending", pendingVec, '0);
    checkVec("R1 reset mask", maskVec, '0);
    checkVec("R1 reset active", activeVec, '0);
    rstN = 1'b1;
    tick("R1 first cycle", 32'h0, 32'h0);
    enableCmd = 32'h3F;
    tick("R3 enable", 32'h0, 32'h3F);
    disableCmd = 32'h8000_0020; enableCmd = 32'h8000_0000;
    m = 32'h8000_001F;
    tick("R3 disable and enable wins", 32'h0, m);
    irqIn[0] = 1'b1;
    tick("R2 R4 high level", 32'h1, m);
    forceClrCmd = 32'h1;
    tick("R4 clear while active", 32'h1, m);
    irqIn[0] = 1'b0;
    tick("R4 level gone", 32'h0, m);
    irqIn[1] = 1'b0;
    tick("R2 R4 low level", 32'h2, m);
    irqIn[1] = 1'b1;
    tick("R4 low level gone", 32'h0, m);
    irqIn[2] = 1'b1;
    tick("R2 R6 rising edge", 32'h4, m);
    irqIn[2] = 1'b0;
    tick("R6 edge sticky", 32'h4, m);
    ackValid = 1'b1; ackId = 5'd2;
    tick("R7 ack edge source", 32'h0, m);
    irqIn[3] = 1'b0;
    tick("R2 R6 falling edge", 32'h8, m);
    irqIn[3] = 1'b1;
    tick("R6 rise ignored on falling source", 32'h8, m);
    forceClrCmd = 32'h8;
    tick("R5 clear edge latch", 32'h0, m);
    forceSetCmd = 32'h20;
    tick("R5 force level source", 32'h20, m);
    ackValid = 1'b1; ackId = 5'd5;
    tick("R7 ack level source ignored", 32'h20, m);
    tick("R5 force sticky", 32'h20, m);
    forceClrCmd = 32'h20;
    tick("R5 clear forced", 32'h0, m);
    forceSetCmd = 32'h10; forceClrCmd = 32'h10;
    tick("R5 force beats clear", 32'h10, m);
    ackValid = 1'b1; ackId = 5'd4;
    tick("R7 ack forced edge source", 32'h0, m);
    irqIn[2] = 1'b1; ackValid = 1'b1; ackId = 5'd2;
    tick("R7 edge beats ack", 32'h4, m);
    irqIn[2] = 1'b0; forceClrCmd = 32'h4;
    tick("R5 clear after race", 32'h0, m);
    forceSetCmd = 32'h8000_0040;
    tick("R8 active masks disabled source", 32'h8000_0040, m);
    enableCmd = 32'h40;
    tick("R3 R8 enable pending source", 32'h8000_0040, m | 32'h40);
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule